// File: doc/BRIEF.md
# Multi-Channel Interrupt Multiplexer

This block folds a bank of level-sensitive, active-high interrupt sources onto a few interrupt lines. All channels see every source at once. Each channel keeps its own enable mask, offers a read-only view of its pending sources and drives one output line. That line stays high while at least one enabled source of the channel is high.

Software reaches the block through a simple word-wide register port. A write takes effect on the clock edge where select and write are both high. Read data appears on the edge that samples a read and then holds until the next read. Sources may come from other clock domains, so they pass through a two-flop synchronizer before they are masked. To mask or unmask a single source, software does a read-modify-write of the channel's enable word. To restore a channel, software writes back an enable word it saved earlier.

Top module: `imux_top`

## Requirements
- R1: After reset, every enable mask is zero, every output line is low and the read data is zero.
- R2: The enable word of channel n sits at byte address 0x10 + 0x40*n. All 32 bits can be written, and a read returns the full word.
- R3: Reading byte address 0x20 + 0x40*n returns the pending word of channel n. Bit k is the synchronized level of source k ANDed with enable bit k of that channel.
- R4: Output line n is high exactly when at least one bit of channel n's pending word is set. It drops as soon as every enabled source of the channel is low again.
- R5: A source change reaches the pending words and output lines after exactly two rising clock edges, and no earlier.
- R6: Writing zero to a channel's enable word silences that channel's output from the following cycle, even while its sources stay high.
- R7: Writes to a pending-word address leave every enable mask unchanged.
- R8: Reads of any other address return zero, including misaligned byte addresses. Writes to such addresses change nothing.
- R9: A write to one channel's enable word leaves the masks of all other channels unchanged.
- R10: Read data updates only on the edge that samples a read (select high, write low), and holds its value otherwise.
- R11: If a saved enable word is written back, the channel's pending word and output are the same as before the mask was cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive interrupt sources, active high, asynchronous |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 9 | Byte address: bits 8:6 pick the channel, bits 5:0 the offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid from the edge after a read and held until the next read |
| irq_o | output | 8 | One interrupt line per channel |

## Verification
The hardest case to reach is the exact two-edge delay through the synchronizer while a channel's mask changes in the same window. In that window the pending word mixes an old source level with a new mask. The bench keeps a behavioural model of the two-deep source history and of every mask. It runs a long stretch of random source patterns interleaved with random mask writes, reads of both register kinds, and accesses to unmapped and misaligned addresses, so that mask and source changes often land within the same two cycles. Directed steps then pin down the one-edge and two-edge points after a single source rises, and the save-clear-restore sequence.

// File: rtl/imux_pkg.sv
`timescale 1ns/1ps
package imux_pkg;
    localparam int OFF_W    = 6;        // byte offset bits inside one channel window
    localparam int OFF_EN   = 'h10;     // enable word offset
    localparam int OFF_PEND = 'h20;     // pending word offset

    typedef enum logic [1:0] {
        HIT_NONE = 2'd0,
        HIT_EN   = 2'd1,
        HIT_PEND = 2'd2
    } hit_e;

    function automatic hit_e decode_off(input logic [OFF_W-1:0] off);
        if (off == OFF_W'(OFF_EN))        return HIT_EN;
        else if (off == OFF_W'(OFF_PEND)) return HIT_PEND;
        else                              return HIT_NONE;
    endfunction
endpackage

// File: rtl/imux_sync.sv
`timescale 1ns/1ps
module imux_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= d_i;
            stable_q <= meta_q;
        end
    end

    assign q_o = stable_q;
endmodule

// File: rtl/imux_chan.sv
`timescale 1ns/1ps
module imux_chan #(
    parameter int NSRC = 32
) (
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] en_i,
    output logic [NSRC-1:0] pend_o,
    output logic            irq_o
);
    always_comb begin
        pend_o = src_i & en_i;
        irq_o  = |pend_o;
    end
endmodule

// File: rtl/imux_regs.sv
`timescale 1ns/1ps
module imux_regs
    import imux_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int NSRC = 32,
    parameter int DW   = 32,
    parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
    parameter int AW   = CH_W + OFF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel_i,
    input  logic                 bus_wr_i,
    input  logic [AW-1:0]        bus_addr_i,
    input  logic [DW-1:0]        bus_wdata_i,
    input  logic [NCH*NSRC-1:0]  pend_i,
    output logic [NCH*NSRC-1:0]  en_o,
    output logic [DW-1:0]        bus_rdata_o
);
    logic [CH_W-1:0] ch;
    hit_e            hit;
    logic            wr_hit_en;
    logic            rd_req;
    logic [NSRC-1:0] en_q [NCH];
    logic [DW-1:0]   rd_next;

    assign ch     = bus_addr_i[AW-1:OFF_W];
    assign hit    = ({1'b0, ch} < (CH_W+1)'(NCH)) ? decode_off(bus_addr_i[OFF_W-1:0]) : HIT_NONE;
    assign rd_req = bus_sel_i && !bus_wr_i;
    assign wr_hit_en = bus_sel_i && bus_wr_i && (hit == HIT_EN);

    for (genvar c = 0; c < NCH; c++) begin : g_en
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                en_q[c] <= '0;
            else if (wr_hit_en && (ch == CH_W'(c)))
                en_q[c] <= bus_wdata_i[NSRC-1:0];
        end
        assign en_o[c*NSRC +: NSRC] = en_q[c];
    end

    always_comb begin
        rd_next = '0;
        unique case (hit)
            HIT_EN:   rd_next = DW'(en_q[ch]);
            HIT_PEND: rd_next = DW'(pend_i[ch*NSRC +: NSRC]);
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata_o <= '0;
        else if (rd_req)
            bus_rdata_o <= rd_next;
    end

    assert_pend_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && bus_wr_i && hit == HIT_PEND) |=> $stable(en_o));

    assert_unmapped_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && bus_wr_i && hit == HIT_NONE) |=> $stable(en_o));

    assert_unmapped_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && hit == HIT_NONE) |=> (bus_rdata_o == '0));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(bus_rdata_o));
endmodule

// File: rtl/imux_top.sv
`timescale 1ns/1ps
module imux_top
    import imux_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int NSRC = 32,
    parameter int DW   = 32,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int AW   = CH_W + OFF_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic            bus_sel_i,
    input  logic            bus_wr_i,
    input  logic [AW-1:0]   bus_addr_i,
    input  logic [DW-1:0]   bus_wdata_i,
    output logic [DW-1:0]   bus_rdata_o,
    output logic [NCH-1:0]  irq_o
);
    logic [NSRC-1:0]     src_sync;
    logic [NCH*NSRC-1:0] en_flat;
    logic [NCH*NSRC-1:0] pend_flat;

    imux_sync #(.W(NSRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (src_i),
        .q_o   (src_sync)
    );

    imux_regs #(.NCH(NCH), .NSRC(NSRC), .DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel_i   (bus_sel_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .pend_i      (pend_flat),
        .en_o        (en_flat),
        .bus_rdata_o (bus_rdata_o)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        imux_chan #(.NSRC(NSRC)) u_chan (
            .src_i  (src_sync),
            .en_i   (en_flat[c*NSRC +: NSRC]),
            .pend_o (pend_flat[c*NSRC +: NSRC]),
            .irq_o  (irq_o[c])
        );

        assert_clear_silences_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel_i && bus_wr_i && bus_addr_i == AW'(c*64 + OFF_EN)
             && bus_wdata_i[NSRC-1:0] == '0) |=> !irq_o[c]);
    end

    // cycles since reset release, saturating, used only to gate the delay check
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               warm_q <= 2'd0;
        else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
    end

    assert_sync_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (src_sync == $past(src_i, 2)));
endmodule

// File: tb/sim_imux_top.sv
`timescale 1ns/1ps
module sim_imux_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit live = 1'b0;
    bit done = 1'b0;

    imux_top u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
    );

    always #2 clk = ~clk;

    // behavioural reference: masks, two-deep source history, read register
    logic [31:0] en_m [8];
    logic [31:0] s1 = '0, s2 = '0, rd_m = '0;
    initial for (int c = 0; c < 8; c++) en_m[c] = '0;

    always @(posedge clk or negedge rst_n) begin
        int ch, off;
        if (!rst_n) begin
            for (int c = 0; c < 8; c++) en_m[c] = '0;
            s1 = '0; s2 = '0; rd_m = '0;
        end else begin
            ch  = int'(bus_addr[8:6]);
            off = int'(bus_addr[5:0]);
            if (bus_sel && !bus_wr)
                rd_m = (off == 16) ? en_m[ch] : (off == 32) ? (en_m[ch] & s2) : 32'h0;
            if (bus_sel && bus_wr && off == 16) en_m[ch] = bus_wdata;
            s2 = s1;
            s1 = src;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (live) begin
        logic [7:0] ei;
        for (int c = 0; c < 8; c++) ei[c] = |(en_m[c] & s2);
        chk(irq === ei, "R4 output lines vs model", 32'(irq), 32'(ei));
        chk(bus_rdata === rd_m, "R10 read data vs model", bus_rdata, rd_m);
    end

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired act=%h exp=%h", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        logic [31:0] v, saved, pv;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        live = 1;
        // R1 reset state
        chk(irq == 8'h0, "R1 irq after reset", 32'(irq), 0);
        chk(bus_rdata == 0, "R1 rdata after reset", bus_rdata, 0);
        rd(9'h0D0, v); chk(v == 0, "R1 ch3 enable after reset", v, 0);
        // R2 read/write enable
        wr(9'h010, 32'hA5A5_0001); rd(9'h010, v);
        chk(v == 32'hA5A5_0001, "R2 ch0 enable readback", v, 32'hA5A5_0001);
        wr(9'h1D0, 32'hFFFF_FFFF); rd(9'h1D0, v);
        chk(v == 32'hFFFF_FFFF, "R2 ch7 enable readback", v, 32'hFFFF_FFFF);
        // R9 other channel untouched
        rd(9'h050, v); chk(v == 0, "R9 ch1 enable untouched", v, 0);
        // R5 two-edge delay
        src = 32'h1;
        @(negedge clk);
        chk(irq[0] == 0, "R5 no output after one edge", 32'(irq[0]), 0);
        @(negedge clk);
        chk(irq[0] == 1, "R5 output after two edges", 32'(irq[0]), 1);
        chk(irq[7] == 1, "R4 ch7 output", 32'(irq[7]), 1);
        // R3 pending
        rd(9'h020, v); chk(v == 32'h1, "R3 ch0 pending", v, 32'h1);
        src = 32'hFFFF_FFFF; repeat (2) @(negedge clk);
        rd(9'h020, v); chk(v == 32'hA5A5_0001, "R3 ch0 pending masked", v, 32'hA5A5_0001);
        // R7 pending write ignored
        wr(9'h060, 32'hFFFF_FFFF); rd(9'h050, v);
        chk(v == 0, "R7 ch1 enable after pending write", v, 0);
        chk(irq[1] == 0, "R7 ch1 output stays low", 32'(irq[1]), 0);
        // R8 unmapped
        rd(9'h014, v); chk(v == 0, "R8 unmapped read", v, 0);
        rd(9'h011, v); chk(v == 0, "R8 misaligned read", v, 0);
        wr(9'h012, 32'h0000_FFFF); wr(9'h000, 32'h1234_5678);
        rd(9'h010, v); chk(v == 32'hA5A5_0001, "R8 unmapped write no effect", v, 32'hA5A5_0001);
        // R10 hold
        repeat (3) @(negedge clk);
        chk(bus_rdata == 32'hA5A5_0001, "R10 rdata held when idle", bus_rdata, 32'hA5A5_0001);
        // R4 deassert
        src = 0; repeat (2) @(negedge clk);
        chk(irq == 8'h0, "R4 outputs drop with sources", 32'(irq), 0);
        // R6 clear silences
        src = 32'hFFFF_FFFF; repeat (2) @(negedge clk);
        wr(9'h1D0, 32'h0);
        chk(irq[7] == 0, "R6 ch7 silenced by zero write", 32'(irq[7]), 0);
        rd(9'h1E0, v); chk(v == 0, "R6 ch7 pending after clear", v, 0);
        // R11 save, clear, restore
        rd(9'h010, saved); rd(9'h020, pv);
        wr(9'h010, 32'h0);
        chk(irq[0] == 0, "R11 cleared channel low", 32'(irq[0]), 0);
        wr(9'h010, saved); rd(9'h020, v);
        chk(v == pv, "R11 pending restored", v, pv);
        chk(irq[0] == 1, "R11 output restored", 32'(irq[0]), 1);
        // random mix, compared every clock against the model
        for (int i = 0; i < 2000; i++) begin
            int k;
            src = $urandom & $urandom;
            k = $urandom_range(0, 3);
            if (k == 0) wr({3'($urandom_range(0, 7)), 6'h10}, $urandom);
            else if (k == 1) rd({3'($urandom_range(0, 7)), 6'h20}, v);
            else if (k == 2) rd(9'($urandom), v);
            else if ($urandom_range(0, 7) == 0) wr(9'($urandom), $urandom);
            else @(negedge clk);
        end
        finish_run();
    end
endmodule